// File: doc/BRIEF.md
# Level-Sampled Two-Wire Serial Memory Target

This block is a small two-wire serial memory that software drives by writing line levels instead of running a real bus clock. Each write strobe carries a new clock level and a new data level. The block compares them with the levels it latched on the previous strobe. From that comparison it finds bus conditions (start and stop) and rising clock edges, and it frames bits with a single slot counter.

After a start, eight bits form a command byte whose lowest bit chooses read or write. An acknowledge slot follows, in which the block pulls the data line low. A write command then takes an eight-bit word address. When the last address bit arrives, the byte stored there is fetched into a data shifter. A later read command, usually issued after a repeated start, shifts that byte out most significant bit first on the next eight rising edges. Software reads the data-line level back as bit 0 of a status word. The upper bits of that word pass through from an auxiliary input.

The 256-byte store is loaded through a separate preload port. A parameter narrows the store to 128 bytes, in which case only the low seven address bits select a location.

Top module: `sbee_slave`

## Requirements
- R1: After reset the latched clock and data levels are both 1, so `sda_o` is 1, `ack_o` is 0 and the block is idle.
- R2: A strobe whose latched clock and new clock are both 1 is a bus condition when the data level changes. Data going 1 to 0 is a start: framing restarts at the first command bit and any pending acknowledge clears. Data going 0 to 1 is a stop: the block returns to idle with no acknowledge pending.
- R3: While idle (slot counter zero, no acknowledge pending), strobes other than a start change nothing except the latched levels. In that state `ack_o` never rises.
- R4: A bit is accepted only on a strobe that raises the clock (latched 0, new 1) while `sda_i` equals the latched data level. A rising strobe with a changed data level is discarded and is not counted.
- R5: The first eight accepted bits after a start shift into the command byte most significant bit first. Command bit 0 = 1 selects read and 0 selects write.
- R6: The eighth command bit sets `ack_o`. The next rising strobe is the acknowledge slot: it drives `sda_o` to 0 whatever `sda_i` is, and it clears `ack_o`.
- R7: With a write command, the next eight accepted bits shift into the word address most significant bit first. The eighth one loads the stored byte at that address into the data shifter, sets `ack_o`, and returns the slot counter to zero, so the block is idle once that acknowledge slot has passed.
- R8: With a read command, each of the next eight accepted bits drives `sda_o` from the shifter's top bit, and the shifter then moves left one place. The returned byte is therefore the fetched byte, most significant bit first, and `ack_o` is set after the eighth bit.
- R9: On every other strobe, `sda_o` takes the level of `sda_i`. `stat_o` is always `{aux_i, sda_o}`, with the line level in bit 0.
- R10: A cycle with `pl_we` high stores `pl_data` at `pl_addr`. A later fetch of that address returns the new value.
- R11: In cycles with `wr_en` low, `sda_o`, `ack_o` and the framing state hold, whatever `scl_i` and `sda_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Line-level write strobe |
| scl_i | input | 1 | New clock level carried by the strobe |
| sda_i | input | 1 | New data level carried by the strobe |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | ADDR_W | Preload address |
| pl_data | input | 8 | Preload byte |
| aux_i | input | AUX_W-1 | Upper bits of the status word |
| sda_o | output | 1 | Latched data-line level seen by the host |
| ack_o | output | 1 | Acknowledge slot pending |
| stat_o | output | AUX_W | Status word, line level in bit 0 |

## Verification
The main read path runs with random store contents at random word addresses and at the two edge addresses, 0x00 and 0xFF. Returned bytes that mix ones and zeros show whether the bit order and shifter alignment are right. A rising strobe with a skewed data level is placed in front of a command byte: if the design counts it, the acknowledge comes one bit early. A start is issued while an acknowledge is pending, and a stop is issued in the middle of a byte. These show that the counter restarts at the first bit or goes idle as required, and that bits clocked while idle never produce an acknowledge. Overwriting a preloaded byte and reading it back tells a fetch from the live store apart from one taken from stale contents.

// File: rtl/sbee_pkg.sv
package sbee_pkg;

  localparam int W_BYTE = 8;

  typedef logic [W_BYTE-1:0] octet_t;

  typedef enum logic [1:0] {
    LE_NONE,
    LE_START,
    LE_STOP,
    LE_RISE
  } line_ev_e;

  // Classify one strobe against the previously latched levels.
  function automatic line_ev_e line_event(input logic ps, input logic pd,
                                          input logic s, input logic d);
    if (ps && s && (pd != d)) return d ? LE_STOP : LE_START;
    if (!ps && s) return LE_RISE;
    return LE_NONE;
  endfunction

  // Shift one bit in at the bottom, MSB-first framing.
  function automatic octet_t shl_in(input octet_t v, input logic b);
    return {v[W_BYTE-2:0], b};
  endfunction

endpackage

// File: rtl/sbee_cond.sv
module sbee_cond
  import sbee_pkg::*;
(
  input  logic prev_scl,
  input  logic prev_sda,
  input  logic scl_i,
  input  logic sda_i,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_steady
);

  line_ev_e ev;

  assign ev        = line_event(prev_scl, prev_sda, scl_i, sda_i);
  assign ev_start  = (ev == LE_START);
  assign ev_stop   = (ev == LE_STOP);
  assign ev_rise   = (ev == LE_RISE);
  assign ev_steady = (prev_sda == sda_i);

endmodule

// File: rtl/sbee_mem.sv
module sbee_mem
  import sbee_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  octet_t            wdata,
  input  logic [ADDR_W-1:0] raddr,
  output octet_t            rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  octet_t arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];

endmodule

// File: rtl/sbee_core.sv
module sbee_core
  import sbee_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_steady,
  input  octet_t            mem_rdata,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              scl_q,
  output logic              sda_q,
  output logic              ack_q
);

  localparam int ACK_SLOT   = W_BYTE + 1;
  localparam int FETCH_SLOT = 2 * W_BYTE + 1;
  localparam int CNT_W      = $clog2(FETCH_SLOT + 1);
  localparam logic [CNT_W-1:0] C_ZERO     = '0;
  localparam logic [CNT_W-1:0] C_FIRST    = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_ACK      = CNT_W'(ACK_SLOT);
  localparam logic [CNT_W-1:0] C_LAST_CMD = CNT_W'(ACK_SLOT - 1);
  localparam logic [CNT_W-1:0] C_LAST_ADR = CNT_W'(FETCH_SLOT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  octet_t cmd_q, cmd_d, adr_q, adr_d, dsh_q, dsh_d;
  logic   ack_d, line_d;
  octet_t adr_shift;

  // Named internal events, shared by the logic and the assertions.
  wire idle     = (cnt_q == C_ZERO) && !ack_q;
  wire ev_cond  = ev_start | ev_stop;
  wire in_cmd   = (cnt_q < C_ACK);
  wire is_read  = cmd_q[0];
  wire edge_ok  = wr_en & ~ev_cond & ~idle & ev_rise;
  wire ack_slot = edge_ok & ack_q;
  wire take_bit = edge_ok & ~ack_q & ev_steady;
  wire last_cmd = take_bit & in_cmd & (cnt_q == C_LAST_CMD);
  wire last_adr = take_bit & ~in_cmd & (cnt_q == C_LAST_ADR);

  assign adr_shift  = shl_in(adr_q, sda_i);
  assign fetch_addr = adr_shift[ADDR_W-1:0];

  always_comb begin
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    adr_d  = adr_q;
    dsh_d  = dsh_q;
    ack_d  = ack_q;
    line_d = sda_i;
    if (wr_en) begin
      if (ev_start) begin
        cnt_d = C_FIRST;
        cmd_d = '0;
        ack_d = 1'b0;
      end else if (ev_stop) begin
        cnt_d = C_ZERO;
        ack_d = 1'b0;
      end else if (ack_slot) begin
        line_d = 1'b0;
        ack_d  = 1'b0;
      end else if (take_bit) begin
        cnt_d = cnt_q + C_FIRST;
        if (in_cmd) begin
          cmd_d = shl_in(cmd_q, sda_i);
          if (last_cmd) ack_d = 1'b1;
        end else begin
          if (is_read) line_d = dsh_q[W_BYTE-1];
          adr_d = adr_shift;
          dsh_d = {dsh_q[W_BYTE-2:0], 1'b0};
          if (last_adr) begin
            dsh_d = mem_rdata;
            ack_d = 1'b1;
            cnt_d = C_ZERO;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnt_q <= C_ZERO;
      ack_q <= 1'b0;
      cmd_q <= '0;
      adr_q <= '0;
      dsh_q <= '0;
    end else begin
      if (wr_en) begin
        scl_q <= scl_i;
        sda_q <= line_d;
      end
      cnt_q <= cnt_d;
      ack_q <= ack_d;
      cmd_q <= cmd_d;
      adr_q <= adr_d;
      dsh_q <= dsh_d;
    end
  end

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ev_start |=> (cnt_q == C_FIRST) && !ack_q); // R2
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ev_stop |=> (cnt_q == C_ZERO) && !ack_q); // R2
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idle && !ev_start |=> idle && $stable(cmd_q) && $stable(adr_q)); // R3
  AST_SKEW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !idle && !ack_q && ev_rise && !ev_steady && !ev_cond |=> $stable(cnt_q)); // R4
  AST_CMD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    last_cmd |=> ack_q && (cnt_q == C_ACK)); // R6
  AST_ACK_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slot |=> !sda_q && !ack_q); // R6
  AST_FETCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    last_adr |=> ack_q && (cnt_q == C_ZERO) && (dsh_q == $past(mem_rdata))); // R7
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sda_q) && $stable(scl_q) && $stable(cnt_q) && $stable(ack_q)); // R11

endmodule

// File: rtl/sbee_slave.sv
module sbee_slave
  import sbee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int AUX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [7:0]        pl_data,
  input  logic [AUX_W-2:0]  aux_i,
  output logic              sda_o,
  output logic              ack_o,
  output logic [AUX_W-1:0]  stat_o
);

  logic scl_q, sda_q, ack_q;
  logic ev_start, ev_stop, ev_rise, ev_steady;
  logic [ADDR_W-1:0] fetch_addr;
  octet_t mem_rdata;

  sbee_cond u_cond (
    .prev_scl (scl_q),
    .prev_sda (sda_q),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_steady(ev_steady)
  );

  sbee_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (pl_we),
    .waddr(pl_addr),
    .wdata(pl_data),
    .raddr(fetch_addr),
    .rdata(mem_rdata)
  );

  sbee_core #(.ADDR_W(ADDR_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_rise   (ev_rise),
    .ev_steady (ev_steady),
    .mem_rdata (mem_rdata),
    .fetch_addr(fetch_addr),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .ack_q     (ack_q)
  );

  assign sda_o  = sda_q;
  assign ack_o  = ack_q;
  assign stat_o = {aux_i, sda_q};

endmodule

// File: tb/tb_sbee_slave.sv
module tb_sbee_slave;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, scl = 1'b1, sda = 1'b1;
  logic       pl_we = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;
  logic [6:0] aux = '0;
  logic       sda_o, ack_o;
  logic [7:0] stat_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  logic [7:0] model [256];

  sbee_slave dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .scl_i(scl), .sda_i(sda),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data), .aux_i(aux),
    .sda_o(sda_o), .ack_o(ack_o), .stat_o(stat_o)
  );

  function automatic logic exp_bit(input logic [7:0] v, input int pos);
    return (v >> (7 - pos)) & 8'h01;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic d);
    @(negedge clk);
    wr_en = 1'b1; scl = s; sda = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_start;
    bus_wr(1'b0, 1'b1); bus_wr(1'b1, 1'b1); bus_wr(1'b1, 1'b0); bus_wr(1'b0, 1'b0);
  endtask

  task automatic do_stop;
    bus_wr(1'b0, 1'b0); bus_wr(1'b1, 1'b0); bus_wr(1'b1, 1'b1);
  endtask

  task automatic send_bit(input logic b);
    bus_wr(1'b0, b); bus_wr(1'b1, b); bus_wr(1'b0, b);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(exp_bit(v, i));
  endtask

  task automatic ack_slot;
    bus_wr(1'b0, 1'b1); bus_wr(1'b1, 1'b1);
    check("R6 ack slot drives line low", sda_o, 0);
    check("R6 ack slot clears ack", ack_o, 0);
    bus_wr(1'b0, 1'b1);
  endtask

  task automatic read_byte(output logic [7:0] v);
    v = '0;
    for (int i = 7; i >= 0; i--) begin
      bus_wr(1'b0, 1'b1); bus_wr(1'b1, 1'b1);
      v[i] = sda_o;
      bus_wr(1'b0, 1'b1);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
    model[a] = d;
  endtask

  task automatic read_at(input logic [7:0] a, input string tag);
    logic [7:0] got;
    do_start;
    send_bits(8'hA0, 8);
    check("R5 R6 write command acknowledged", ack_o, 1);
    ack_slot;
    send_bits(a, 8);
    check("R7 address byte acknowledged", ack_o, 1);
    ack_slot;
    do_start;
    send_bits(8'hA1, 8);
    check("R5 read command acknowledged", ack_o, 1);
    ack_slot;
    read_byte(got);
    check({"R8 returned byte ", tag}, got, model[a]);
    check("R8 ack after data byte", ack_o, 1);
    ack_slot;
    do_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    aux = 7'h52;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset line level", sda_o, 1);
    check("R1 reset ack", ack_o, 0);
    check("R9 status word after reset", stat_o, {7'h52, 1'b1});

    for (int a = 0; a < 256; a++) preload(8'(a), 8'($urandom));

    // R11: no strobe, no change
    @(negedge clk);
    scl = 1'b0; sda = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 line holds without strobe", sda_o, 1);
    check("R11 ack holds without strobe", ack_o, 0);

    // R3: idle ignores bits; R9 line follows data
    send_bits(8'h5A, 8);
    send_bit(1'b1);
    check("R3 idle never acknowledges", ack_o, 0);
    bus_wr(1'b0, 1'b0);
    check("R9 line follows data input", sda_o, 0);
    check("R9 status bit0 tracks line", stat_o, {7'h52, 1'b0});

    // R4: skewed rising strobe is not counted
    do_start;
    bus_wr(1'b0, 1'b0); bus_wr(1'b1, 1'b1);
    check("R9 skewed strobe level", sda_o, 1);
    send_bits(8'hA0, 7);
    check("R4 skewed bit not counted", ack_o, 0);
    send_bit(1'b0);
    check("R4 ack after eight valid bits", ack_o, 1);
    ack_slot;
    do_stop;
    check("R2 stop clears ack", ack_o, 0);

    // R2: start while an acknowledge is pending
    do_start;
    send_bits(8'hA1, 7);
    bus_wr(1'b0, 1'b1); bus_wr(1'b1, 1'b1);
    check("R6 ack after command", ack_o, 1);
    bus_wr(1'b1, 1'b0);
    check("R2 start clears pending ack", ack_o, 0);
    bus_wr(1'b0, 1'b0);
    send_bits(8'hA0, 8);
    check("R2 framing restarted at first bit", ack_o, 1);
    ack_slot;
    do_stop;

    // R2: stop in the middle of a byte returns to idle
    do_start;
    send_bits(8'hA0, 4);
    do_stop;
    send_bits(8'hA0, 8);
    check("R2 idle after mid-byte stop", ack_o, 0);

    // R7 R8: edge and random addresses
    read_at(8'h00, "addr 00");
    read_at(8'hFF, "addr FF");
    for (int k = 0; k < 12; k++) read_at(8'($urandom), "random addr");

    // R10: overwrite then read back
    preload(8'h3C, 8'h96);
    read_at(8'h3C, "after preload R10");
    preload(8'h3C, 8'h69);
    read_at(8'h3C, "second preload R10");

    // R7: idle after data acknowledge slot
    do_start;
    send_bits(8'hA0, 8);
    ack_slot;
    send_bits(8'h11, 8);
    ack_slot;
    send_bits(8'hFF, 8);
    check("R7 idle once fetch ack passed", ack_o, 0);
    do_stop;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule